// File: doc/BRIEF.md
# Host Control Port Decoder for a Bidirectional FIFO Pair

This block is the host-side control port of a bidirectional FIFO pair. A host processor reaches it through a chip select, a three-bit address, a write/read select and a port enable, all sampled on one clock. The block turns each access into one of these actions:

- a push strobe toward the outbound (host-to-far) FIFO;
- a pop strobe from the inbound (far-to-host) FIFO;
- a load of a one-word mailbox that bypasses both FIFOs and goes to the far port;
- a load or a readback of one of four almost-empty or almost-full threshold registers, one of each kind for each direction.

Read data is registered and appears on the host data bus. A combinational output-enable tells the host-side bus driver when to drive that bus. The block also recognises a clear request. The request is only honoured while the host port and the far port are both idle. It resets the block's own state and is passed on to the FIFOs. The FIFO memories and the far-side port logic are outside this block.

Top module: `host_port_decoder`

## Requirements
- R1: When `sel_i` or `en_i` is low, no access takes place: `ab_push_o`, `ba_pop_o` and `far_byp_ack_o` stay low, and neither the mailbox, the threshold registers nor `rdata_o` change, except through a clear or a far-side take.
- R2: Address 3'b000 is the FIFO data code. A write access raises `ab_push_o` in the same cycle, with `ab_data_o` equal to `wdata_i`. A read access raises `ba_pop_o` in the same cycle, and at the next clock edge `rdata_o` takes the value of `ba_rdata_i`.
- R3: Address 3'b001 is the bypass code. A write loads `wdata_i` into the mailbox, and after the next edge `byp_data_o` holds that word and `byp_vld_o` is 1. A read raises `far_byp_ack_o` in the same cycle, and at the next edge `rdata_o` takes the value of `far_byp_data_i`.
- R4: Addresses 3'b1xx are the threshold codes. A write loads `wdata_i[OFS_W-1:0]` into the register selected by `addr_i[1:0]`. The registers are packed into `ofs_o`, each OFS_W bits wide, in these slots:

  | `addr_i[1:0]` | Register | Slot of `ofs_o` |
  |---|---|---|
  | 0 | outbound almost-empty | 0, lowest bits |
  | 1 | outbound almost-full | 1 |
  | 2 | inbound almost-empty | 2 |
  | 3 | inbound almost-full | 3 |

- R5: A read of a threshold code places the selected register in `rdata_o[OFS_W-1:0]` at the next edge, with all upper bits zero.
- R6: Addresses 3'b010 and 3'b011 are unmapped. An access to them raises no strobe and changes no register, and a read of them returns zero in `rdata_o`.
- R7: `oe_o` equals `sel_i & ~wr_i`, so it is 0 whenever `sel_i` is low.
- R8: `clr_o` is high exactly when `clr_req_i` is high while `sel_i`, `en_i` and `far_en_i` are all low. A clear request made while any of those three is high is ignored. At the edge where `clr_o` is high, all thresholds become DEF_OFS, `byp_vld_o` becomes 0 and `rdata_o` becomes 0.
- R9: The mailbox valid flag is held until a `far_byp_rd_i` pulse clears it at the next edge. If a host bypass write falls in the same cycle as the take, the write wins: the valid flag stays 1 and the mailbox holds the new word.
- R10: After the asynchronous reset `rst_ni`, every threshold is DEF_OFS (8), `byp_vld_o` is 0 and `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host port clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Chip select, active high |
| addr_i | input | 3 | Resource address |
| wr_i | input | 1 | 1 = write access, 0 = read access |
| en_i | input | 1 | Host port enable, active high |
| far_en_i | input | 1 | Far port enable, used only to qualify a clear request |
| clr_req_i | input | 1 | Clear request |
| wdata_i | input | W | Host write data |
| rdata_o | output | W | Registered host read data |
| oe_o | output | 1 | Host data bus output enable |
| clr_o | output | 1 | Qualified clear, passed on to the FIFOs |
| ab_push_o | output | 1 | Push strobe to the outbound FIFO |
| ab_data_o | output | W | Push data to the outbound FIFO |
| ba_pop_o | output | 1 | Pop strobe to the inbound FIFO |
| ba_rdata_i | input | W | Head word of the inbound FIFO |
| byp_data_o | output | W | Mailbox word offered to the far port |
| byp_vld_o | output | 1 | Mailbox holds an unread word |
| far_byp_rd_i | input | 1 | Far port takes the mailbox word |
| far_byp_data_i | input | W | Bypass word offered by the far port |
| far_byp_ack_o | output | 1 | Host has read the far port's bypass word |
| ofs_o | output | 4*OFS_W | Threshold registers, packed |

## Verification
The assertions take two things for granted.

- The far side pulses `far_byp_rd_i` only while it is free to; the properties only relate that input to the valid flag.
- The FIFO head word on `ba_rdata_i` may change in any cycle. For that reason no property ties `rdata_o` to it, and the bench model covers that path instead.

The stimulus draws every control and data input from a seeded random source. Clear requests are kept rare, and all eight address codes are equally likely, so the unmapped codes and the same-cycle write-and-take case come up often. Directed cycles are added for:

- the state right after reset;
- a clear request blocked by a busy port;
- a qualified clear.

// File: rtl/hpd_pkg.sv
package hpd_pkg;
  typedef enum logic [1:0] {
    RES_FIFO = 2'd0,
    RES_BYP  = 2'd1,
    RES_OFS  = 2'd2,
    RES_NONE = 2'd3
  } res_e;
  localparam int unsigned N_OFS = 4;
endpackage

// File: rtl/hpd_decode.sv
module hpd_decode
  import hpd_pkg::*;
(
  input  logic       sel_i,
  input  logic       en_i,
  input  logic       wr_i,
  input  logic [2:0] addr_i,
  output res_e       res_o,
  output logic       wr_acc_o,
  output logic       rd_acc_o
);
  logic acc;
  assign acc      = sel_i & en_i;
  assign wr_acc_o = acc & wr_i;
  assign rd_acc_o = acc & ~wr_i;

  always_comb begin
    if (addr_i[2])             res_o = RES_OFS;
    else if (addr_i[1])        res_o = RES_NONE;
    else if (addr_i[0])        res_o = RES_BYP;
    else                       res_o = RES_FIFO;
  end
endmodule

// File: rtl/hpd_mailbox.sv
module hpd_mailbox #(
  parameter int unsigned W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] din_i,
  input  logic         take_i,
  output logic [W-1:0] data_o,
  output logic         vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      vld_o  <= 1'b0;
    end else if (clr_i) begin
      vld_o  <= 1'b0;
    end else if (load_i) begin
      data_o <= din_i;
      vld_o  <= 1'b1;   // host write beats a same-cycle take
    end else if (take_i) begin
      vld_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/hpd_ofs_bank.sv
module hpd_ofs_bank #(
  parameter int unsigned OFS_W   = 9,
  parameter int unsigned N       = 4,
  parameter int unsigned DEF_OFS = 8,
  localparam int unsigned IDX_W  = $clog2(N)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [OFS_W-1:0]   din_i,
  output logic [N*OFS_W-1:0] ofs_o
);
  localparam logic [OFS_W-1:0] DEF_V = OFS_W'(DEF_OFS);

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  ofs_o[g*OFS_W +: OFS_W] <= DEF_V;
      else if (clr_i)                               ofs_o[g*OFS_W +: OFS_W] <= DEF_V;
      else if (we_i && idx_i == IDX_W'(g))          ofs_o[g*OFS_W +: OFS_W] <= din_i;
    end
  end
endmodule

// File: rtl/host_port_decoder.sv
module host_port_decoder
  import hpd_pkg::*;
#(
  parameter int unsigned W       = 18,
  parameter int unsigned OFS_W   = 9,
  parameter int unsigned DEF_OFS = 8,
  localparam int unsigned IDX_W  = $clog2(N_OFS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sel_i,
  input  logic [2:0]             addr_i,
  input  logic                   wr_i,
  input  logic                   en_i,
  input  logic                   far_en_i,
  input  logic                   clr_req_i,
  input  logic [W-1:0]           wdata_i,
  output logic [W-1:0]           rdata_o,
  output logic                   oe_o,
  output logic                   clr_o,
  output logic                   ab_push_o,
  output logic [W-1:0]           ab_data_o,
  output logic                   ba_pop_o,
  input  logic [W-1:0]           ba_rdata_i,
  output logic [W-1:0]           byp_data_o,
  output logic                   byp_vld_o,
  input  logic                   far_byp_rd_i,
  input  logic [W-1:0]           far_byp_data_i,
  output logic                   far_byp_ack_o,
  output logic [N_OFS*OFS_W-1:0] ofs_o
);
  res_e             res;
  logic             wr_acc, rd_acc;
  logic [IDX_W-1:0] idx;
  logic [W-1:0]     rd_mux;

  hpd_decode u_dec (
    .sel_i    (sel_i),
    .en_i     (en_i),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .res_o    (res),
    .wr_acc_o (wr_acc),
    .rd_acc_o (rd_acc)
  );

  assign idx           = addr_i[IDX_W-1:0];
  assign clr_o         = clr_req_i & ~sel_i & ~en_i & ~far_en_i;
  assign oe_o          = sel_i & ~wr_i;
  assign ab_push_o     = wr_acc & (res == RES_FIFO);
  assign ab_data_o     = wdata_i;
  assign ba_pop_o      = rd_acc & (res == RES_FIFO);
  assign far_byp_ack_o = rd_acc & (res == RES_BYP);

  hpd_mailbox #(.W(W)) u_mbox (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_o),
    .load_i (wr_acc & (res == RES_BYP)),
    .din_i  (wdata_i),
    .take_i (far_byp_rd_i),
    .data_o (byp_data_o),
    .vld_o  (byp_vld_o)
  );

  hpd_ofs_bank #(.OFS_W(OFS_W), .N(N_OFS), .DEF_OFS(DEF_OFS)) u_ofs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_o),
    .we_i   (wr_acc & (res == RES_OFS)),
    .idx_i  (idx),
    .din_i  (wdata_i[OFS_W-1:0]),
    .ofs_o  (ofs_o)
  );

  always_comb begin
    unique case (res)
      RES_FIFO: rd_mux = ba_rdata_i;
      RES_BYP:  rd_mux = far_byp_data_i;
      RES_OFS:  rd_mux = W'(ofs_o[idx*OFS_W +: OFS_W]);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_o <= '0;
    else if (clr_o)  rdata_o <= '0;
    else if (rd_acc) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/hpd_checker.sv
module hpd_checker #(
  parameter int unsigned W = 18
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         sel_i,
  input logic [2:0]   addr_i,
  input logic         wr_i,
  input logic         en_i,
  input logic         far_en_i,
  input logic [W-1:0] wdata_i,
  input logic [W-1:0] rdata_o,
  input logic         oe_o,
  input logic         clr_o,
  input logic         ab_push_o,
  input logic         ba_pop_o,
  input logic [W-1:0] byp_data_o,
  input logic         byp_vld_o,
  input logic         far_byp_rd_i,
  input logic         far_byp_ack_o
);
  logic byp_wr;
  assign byp_wr = sel_i & en_i & wr_i & (addr_i == 3'b001);

  AST_NO_STROBE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && en_i) |-> !ab_push_o && !ba_pop_o && !far_byp_ack_o); // R1
  AST_PUSH_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ab_push_o |-> wr_i && addr_i == 3'b000); // R2
  AST_BYP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byp_wr && !clr_o |=> byp_vld_o && byp_data_o == $past(wdata_i)); // R3
  AST_UNMAPPED_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && en_i && !wr_i && addr_i[2:1] == 2'b01 |=> rdata_o == '0); // R6
  AST_OE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |-> !oe_o); // R7
  AST_CLR_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |-> !sel_i && !en_i && !far_en_i); // R8
  AST_CLR_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> !byp_vld_o && rdata_o == '0); // R8
  AST_VLD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byp_vld_o && !far_byp_rd_i && !byp_wr && !clr_o |=> byp_vld_o && $stable(byp_data_o)); // R9
endmodule

bind host_port_decoder hpd_checker #(.W(W)) u_hpd_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sel_i         (sel_i),
  .addr_i        (addr_i),
  .wr_i          (wr_i),
  .en_i          (en_i),
  .far_en_i      (far_en_i),
  .wdata_i       (wdata_i),
  .rdata_o       (rdata_o),
  .oe_o          (oe_o),
  .clr_o         (clr_o),
  .ab_push_o     (ab_push_o),
  .ba_pop_o      (ba_pop_o),
  .byp_data_o    (byp_data_o),
  .byp_vld_o     (byp_vld_o),
  .far_byp_rd_i  (far_byp_rd_i),
  .far_byp_ack_o (far_byp_ack_o)
);

// File: tb/host_port_decoder_bench.sv
module host_port_decoder_bench;
  localparam int W = 18;
  localparam int OFS_W = 9;
  localparam int DEF_OFS = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sel, wr, en, far_en, clr_req, far_rd;
  logic [2:0] addr;
  logic [W-1:0] wdata, ba_rdata, far_data;
  logic [W-1:0] rdata, ab_data, byp_data;
  logic oe, clr, push, pop, byp_vld, ack;
  logic [4*OFS_W-1:0] ofs;

  int n_chk = 0, n_bad = 0;
  logic [OFS_W-1:0] m_ofs [4];
  logic [W-1:0] m_rd, m_byp;
  logic m_vld;

  always #4 clk = ~clk;

  host_port_decoder #(.W(W), .OFS_W(OFS_W), .DEF_OFS(DEF_OFS)) u_host_port_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .addr_i(addr), .wr_i(wr), .en_i(en),
    .far_en_i(far_en), .clr_req_i(clr_req), .wdata_i(wdata), .rdata_o(rdata), .oe_o(oe),
    .clr_o(clr), .ab_push_o(push), .ab_data_o(ab_data), .ba_pop_o(pop),
    .ba_rdata_i(ba_rdata), .byp_data_o(byp_data), .byp_vld_o(byp_vld),
    .far_byp_rd_i(far_rd), .far_byp_data_i(far_data), .far_byp_ack_o(ack), .ofs_o(ofs)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    chk("R9", "byp_vld", 64'(byp_vld), 64'(m_vld));
    chk("R3", "byp_data", 64'(byp_data), 64'(m_byp));
    for (int i = 0; i < 4; i++)
      chk("R4", "ofs", 64'(ofs[i*OFS_W +: OFS_W]), 64'(m_ofs[i]));
    chk(tag, "rdata", 64'(rdata), 64'(m_rd));
  endtask

  task automatic cyc(input logic s, input logic e, input logic w, input logic [2:0] a,
                     input logic [W-1:0] d, input logic fe, input logic cr, input logic fr);
    logic acc, e_clr;
    string tag;
    @(negedge clk);
    sel = s; en = e; wr = w; addr = a; wdata = d; far_en = fe; clr_req = cr; far_rd = fr;
    ba_rdata = W'($urandom); far_data = W'($urandom);
    #1;
    acc   = s & e;
    e_clr = cr & ~s & ~e & ~fe;
    chk(acc ? "R2" : "R1", "push", 64'(push), 64'(acc & w & (a == 3'b000)));
    chk(acc ? "R2" : "R1", "pop", 64'(pop), 64'(acc & ~w & (a == 3'b000)));
    chk(acc ? "R3" : "R1", "ack", 64'(ack), 64'(acc & ~w & (a == 3'b001)));
    chk("R7", "oe", 64'(oe), 64'(s & ~w));
    chk("R8", "clr", 64'(clr), 64'(e_clr));
    if (push) chk("R2", "ab_data", 64'(ab_data), 64'(d));
    tag = "R1";
    if (e_clr) begin
      for (int i = 0; i < 4; i++) m_ofs[i] = OFS_W'(DEF_OFS);
      m_vld = 1'b0; m_rd = '0; tag = "R8";
    end else begin
      if (acc && w && a == 3'b001) begin m_byp = d; m_vld = 1'b1; end
      else if (fr) m_vld = 1'b0;
      if (acc && w && a[2]) m_ofs[a[1:0]] = d[OFS_W-1:0];
      if (acc && !w) begin
        if (a == 3'b000)      begin m_rd = ba_rdata; tag = "R2"; end
        else if (a == 3'b001) begin m_rd = far_data; tag = "R3"; end
        else if (a[2])        begin m_rd = W'(m_ofs[a[1:0]]); tag = "R5"; end
        else                  begin m_rd = '0; tag = "R6"; end
      end
    end
    @(posedge clk); #1;
    chk_state(tag);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    sel = 0; en = 0; wr = 0; addr = 0; wdata = 0; far_en = 0; clr_req = 0; far_rd = 0;
    ba_rdata = 0; far_data = 0;
    for (int i = 0; i < 4; i++) m_ofs[i] = OFS_W'(DEF_OFS);
    m_vld = 0; m_byp = '0; m_rd = '0;
    #20 rst_ni = 1'b1;
    @(negedge clk);
    chk_state("R10");
    // directed corner cases
    cyc(1, 1, 1, 3'b101, 18'h3_01ff, 0, 0, 0);   // R4 load outbound almost-full
    cyc(1, 1, 0, 3'b101, 18'h0, 0, 0, 0);        // R5 readback zero-extended
    cyc(1, 1, 1, 3'b010, 18'h3_ffff, 0, 0, 0);   // R6 unmapped write
    cyc(1, 1, 0, 3'b011, 18'h0, 0, 0, 0);        // R6 unmapped read
    cyc(1, 1, 1, 3'b001, 18'h1_2345, 0, 0, 0);   // R3 mailbox load
    cyc(1, 1, 1, 3'b001, 18'h2_abcd, 0, 0, 1);   // R9 write beats take
    cyc(0, 0, 0, 3'b000, 18'h0, 0, 0, 1);        // R9 take clears
    cyc(0, 1, 1, 3'b100, 18'h0_0033, 0, 0, 0);   // R1 disabled write
    cyc(0, 0, 0, 3'b000, 18'h0, 1, 1, 0);        // R8 blocked clear
    cyc(0, 0, 0, 3'b000, 18'h0, 0, 1, 0);        // R8 qualified clear
    for (int n = 0; n < 3000; n++)
      cyc(1'($urandom), ($urandom % 4) != 0, 1'($urandom), 3'($urandom), W'($urandom),
          ($urandom % 4) == 0, ($urandom % 40) == 0, ($urandom % 3) == 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule